// File: doc/BRIEF.md
# Protected-Mode Segment Register Loader

This block loads a 16-bit selector into one of several segment registers. It splits the selector into a table index, a table choice bit and a requested privilege level. It then forms the descriptor address from the global or the local table base and fetches the 8-byte descriptor as two 32-bit reads over a valid/ready memory port. Next it checks that the descriptor is present and that the caller is privileged enough. When the load succeeds, it writes the descriptor back with its accessed bit set and caches the base, the granularity-scaled limit and the attribute bits in the register's hidden part.

After a segment register has been loaded, the block checks every offset against that register's cached limit, with no further permission checks. For expand-down data segments the check is reversed. A load ends with exactly one single-cycle pulse: `done` on success, or `fault` together with a fault code.

Back-pressure works as follows. A load request is taken on a cycle where `ld_valid` and `ld_ready` are both high. `ld_ready` stays low from acceptance until the outcome pulse. A memory request stays valid with address, data and write flag held stable until `mem_req_ready` is seen high. Read data is taken only on a cycle where `mem_rsp_valid` and `mem_rsp_ready` are both high. Writes produce no response.

Top module: `seg_load_unit`

## Requirements
- R1: A selector splits into index = bits 15:3, table choice = bit 2 (0 global, 1 local) and RPL = bits 1:0. The low descriptor word is read at table base + index*8, then the high word at that address + 4.
- R2: If index*8+7 exceeds the chosen table limit, the load faults with code 1 and issues no memory request.
- R3: If the present flag (high word bit 15) is 0, the load faults with code 2, nothing is written back, and the target register keeps its earlier contents.
- R4: The effective level is the numerically larger of the CPL (bits 1:0 of `cs_sel`) and the RPL. If that level exceeds the DPL (high word bits 14:13), the load faults with code 3 and nothing changes.
- R5: On success the cached base is {hi[31:24], hi[7:0], lo[31:16]}. The 20-bit limit {hi[19:16], lo[15:0]} is cached as-is when the granularity flag (hi bit 23) is 0. When that flag is 1, it is shifted left 12 bits with ones filled in below.
- R6: On success, before `done`, the high word is written back to address + 4 with bit 8 (the accessed flag) set and every other bit unchanged.
- R7: Each accepted load ends in exactly one single-cycle pulse: `done`, or `fault` with a nonzero `fault_code`. The two never coincide.
- R8: For a normal segment, `acc_fault` is high when the offset exceeds the cached limit or the register was never loaded.
- R9: An expand-down segment (hi bit 12 = 1, type bit 11 = 0, type bit 10 = 1) faults for offsets at or below the limit and passes offsets above it.
- R10: `ld_ready` is high only while idle. A pending memory request holds address, data and write flag stable until accepted.
- R11: After reset every segment register is invalid, `ld_ready` is high and no outcome pulse or memory request is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_sel | input | 16 | Current code segment selector; bits 1:0 give the CPL |
| gdt_base | input | 32 | Global table base address |
| gdt_limit | input | 32 | Global table last valid byte offset |
| ldt_base | input | 32 | Local table base address |
| ldt_limit | input | 32 | Local table last valid byte offset |
| ld_valid | input | 1 | Load request valid |
| ld_ready | output | 1 | Loader idle and accepting |
| ld_seg | input | SEG_W | Target segment register |
| ld_sel | input | 16 | Selector to load |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Byte address |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Loader waiting for read data |
| mem_rsp_data | input | 32 | Read data |
| done | output | 1 | Successful load pulse |
| fault | output | 1 | Failed load pulse |
| fault_code | output | 2 | 1 table bound, 2 not present, 3 privilege |
| acc_seg | input | SEG_W | Register selected for access check and readout |
| acc_off | input | 32 | Offset to check |
| acc_valid | output | 1 | Selected register holds a loaded segment |
| acc_base | output | 32 | Cached base |
| acc_limit | output | 32 | Cached scaled limit |
| acc_attr | output | 12 | Cached {G, D, L, AVL, P, DPL, S, type} |
| acc_fault | output | 1 | Offset violates the cached limit |

## Verification
A wrong sequencer state shows at the memory port within one or two cycles: a request appears while `ld_ready` is high, an address changes under back-pressure, or an outcome pulse repeats or fails to appear. A wrong cached base, limit or expand-down flag shows up only when that register is read or an offset is checked. For that reason, every load is followed at once by a readout, and the limit boundaries of each kind of segment are probed after the loads. A wrongly gated privilege or presence decision shows as a changed cache entry or as a write-back where none belongs, seen in the same cycle as the outcome pulse.

// File: rtl/seg_pkg.sv
package seg_pkg;

  localparam int WORD_W  = 32;
  localparam int SEL_W   = 16;
  localparam int ATTR_W  = 12;
  localparam int ACC_BIT = 8;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_TABLE  = 2'd1,
    FLT_ABSENT = 2'd2,
    FLT_PRIV   = 2'd3
  } fault_e;

  typedef struct packed {
    logic [WORD_W-1:0] base;
    logic [WORD_W-1:0] limit;
    logic [ATTR_W-1:0] attr;
    logic              expand_down;
  } seg_entry_t;

  function automatic logic [1:0] weaker_level(input logic [1:0] a, input logic [1:0] b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/seg_sel_decode.sv
module seg_sel_decode
  import seg_pkg::*;
(
  input  logic [SEL_W-1:0]  sel,
  input  logic [WORD_W-1:0] gdt_base,
  input  logic [WORD_W-1:0] gdt_limit,
  input  logic [WORD_W-1:0] ldt_base,
  input  logic [WORD_W-1:0] ldt_limit,
  output logic [WORD_W-1:0] desc_addr,
  output logic              over_limit
);
  localparam int IDX_W = SEL_W - 3;

  logic [IDX_W-1:0]  idx;
  logic              use_local;
  logic [WORD_W-1:0] offs;
  logic [WORD_W-1:0] last_byte;
  logic [WORD_W-1:0] tbl_base;
  logic [WORD_W-1:0] tbl_limit;

  always_comb begin
    idx       = sel[SEL_W-1:3];
    use_local = sel[2];
    offs      = {{(WORD_W-IDX_W-3){1'b0}}, idx, 3'b000};
    last_byte = {{(WORD_W-IDX_W-3){1'b0}}, idx, 3'b111};
    tbl_base  = use_local ? ldt_base  : gdt_base;
    tbl_limit = use_local ? ldt_limit : gdt_limit;
    desc_addr = tbl_base + offs;
    over_limit = last_byte > tbl_limit;
  end

  // sel[1:0] carries the RPL, consumed by the loader directly
  logic unused_rpl;
  assign unused_rpl = ^sel[1:0];

endmodule

// File: rtl/seg_desc_check.sv
module seg_desc_check
  import seg_pkg::*;
(
  input  logic [WORD_W-1:0] lo_word,
  input  logic [WORD_W-1:0] hi_word,
  input  logic [1:0]        cpl,
  input  logic [1:0]        rpl,
  output seg_entry_t        entry,
  output logic              present,
  output logic              priv_ok
);
  logic [19:0] raw_limit;
  logic        gran;
  logic        app_desc;
  logic [3:0]  typ;
  logic [1:0]  dpl;
  logic [1:0]  eff_level;

  always_comb begin
    raw_limit = {hi_word[19:16], lo_word[15:0]};
    gran      = hi_word[23];
    app_desc  = hi_word[12];
    typ       = hi_word[11:8];
    dpl       = hi_word[14:13];
    present   = hi_word[15];

    entry.base  = {hi_word[31:24], hi_word[7:0], lo_word[31:16]};
    entry.limit = gran ? {raw_limit, 12'hFFF} : {12'h000, raw_limit};
    entry.attr  = {hi_word[23:20], hi_word[15:8]};
    entry.expand_down = app_desc && !typ[3] && typ[2];

    eff_level = weaker_level(cpl, rpl);
    priv_ok   = eff_level <= dpl;
  end

endmodule

// File: rtl/seg_cache.sv
module seg_cache
  import seg_pkg::*;
#(
  parameter int NUM_SEGS = 4,
  parameter int SEG_W    = 2
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEG_W-1:0]  wr_idx,
  input  seg_entry_t        wr_entry,
  input  logic [SEG_W-1:0]  acc_idx,
  input  logic [WORD_W-1:0] acc_off,
  output logic              acc_valid,
  output seg_entry_t        acc_entry,
  output logic              acc_fault
);
  seg_entry_t          ent_q [NUM_SEGS];
  logic [NUM_SEGS-1:0] vld_q;

  for (genvar g = 0; g < NUM_SEGS; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q[g] <= '0;
        vld_q[g] <= 1'b0;
      end else if (wr_en && (wr_idx == SEG_W'(g))) begin
        ent_q[g] <= wr_entry;
        vld_q[g] <= 1'b1;
      end
    end
  end

  logic in_range;

  always_comb begin
    acc_valid = 1'b0;
    acc_entry = '0;
    for (int i = 0; i < NUM_SEGS; i++) begin
      if (acc_idx == SEG_W'(i)) begin
        acc_valid = vld_q[i];
        acc_entry = ent_q[i];
      end
    end
    if (acc_entry.expand_down) in_range = acc_off > acc_entry.limit;
    else                       in_range = acc_off <= acc_entry.limit;
    acc_fault = !acc_valid || !in_range;
  end

endmodule

// File: rtl/seg_load_unit.sv
module seg_load_unit
  import seg_pkg::*;
#(
  parameter int NUM_SEGS = 4,
  parameter int SEG_W    = (NUM_SEGS > 1) ? $clog2(NUM_SEGS) : 1
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cs_sel,
  input  logic [31:0]       gdt_base,
  input  logic [31:0]       gdt_limit,
  input  logic [31:0]       ldt_base,
  input  logic [31:0]       ldt_limit,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [SEG_W-1:0]  ld_seg,
  input  logic [15:0]       ld_sel,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [31:0]       mem_req_addr,
  output logic [31:0]       mem_req_wdata,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [31:0]       mem_rsp_data,
  output logic              done,
  output logic              fault,
  output logic [1:0]        fault_code,
  input  logic [SEG_W-1:0]  acc_seg,
  input  logic [31:0]       acc_off,
  output logic              acc_valid,
  output logic [31:0]       acc_base,
  output logic [31:0]       acc_limit,
  output logic [11:0]       acc_attr,
  output logic              acc_fault
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_RQ_LO, ST_RS_LO, ST_RQ_HI, ST_RS_HI, ST_RQ_WB
  } st_e;

  st_e               st_q, st_d;
  logic [SEG_W-1:0]  seg_q;
  logic [1:0]        rpl_q, cpl_q;
  logic [WORD_W-1:0] addr_q, lo_q, hi_q;
  logic              done_q, fault_q;
  fault_e            code_q;

  logic              take_ld;
  logic [WORD_W-1:0] dec_addr;
  logic              dec_over;
  logic [WORD_W-1:0] hi_src;
  seg_entry_t        chk_entry;
  logic              chk_present, chk_priv_ok;
  logic              commit;
  logic              done_d, fault_d;
  fault_e            code_d;
  seg_entry_t        rd_entry;

  seg_sel_decode u_dec (
    .sel        (ld_sel),
    .gdt_base   (gdt_base),
    .gdt_limit  (gdt_limit),
    .ldt_base   (ldt_base),
    .ldt_limit  (ldt_limit),
    .desc_addr  (dec_addr),
    .over_limit (dec_over)
  );

  assign hi_src = (st_q == ST_RS_HI) ? mem_rsp_data : hi_q;

  seg_desc_check u_chk_desc (
    .lo_word (lo_q),
    .hi_word (hi_src),
    .cpl     (cpl_q),
    .rpl     (rpl_q),
    .entry   (chk_entry),
    .present (chk_present),
    .priv_ok (chk_priv_ok)
  );

  assign ld_ready      = (st_q == ST_IDLE);
  assign take_ld       = ld_valid && ld_ready;
  assign mem_req_valid = (st_q == ST_RQ_LO) || (st_q == ST_RQ_HI) || (st_q == ST_RQ_WB);
  assign mem_req_we    = (st_q == ST_RQ_WB);
  assign mem_req_addr  = (st_q == ST_RQ_LO) ? addr_q : addr_q + 32'd4;
  assign mem_req_wdata = hi_q | (32'd1 << ACC_BIT);
  assign mem_rsp_ready = (st_q == ST_RS_LO) || (st_q == ST_RS_HI);
  assign commit        = (st_q == ST_RQ_WB) && mem_req_ready;

  always_comb begin
    st_d    = st_q;
    done_d  = 1'b0;
    fault_d = 1'b0;
    code_d  = FLT_NONE;
    unique case (st_q)
      ST_IDLE: if (take_ld) begin
        if (dec_over) begin
          fault_d = 1'b1;
          code_d  = FLT_TABLE;
        end else begin
          st_d = ST_RQ_LO;
        end
      end
      ST_RQ_LO: if (mem_req_ready) st_d = ST_RS_LO;
      ST_RS_LO: if (mem_rsp_valid) st_d = ST_RQ_HI;
      ST_RQ_HI: if (mem_req_ready) st_d = ST_RS_HI;
      ST_RS_HI: if (mem_rsp_valid) begin
        if (!chk_present) begin
          fault_d = 1'b1;
          code_d  = FLT_ABSENT;
          st_d    = ST_IDLE;
        end else if (!chk_priv_ok) begin
          fault_d = 1'b1;
          code_d  = FLT_PRIV;
          st_d    = ST_IDLE;
        end else begin
          st_d = ST_RQ_WB;
        end
      end
      ST_RQ_WB: if (mem_req_ready) begin
        done_d = 1'b1;
        st_d   = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      seg_q   <= '0;
      rpl_q   <= '0;
      cpl_q   <= '0;
      addr_q  <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      code_q  <= FLT_NONE;
    end else begin
      st_q    <= st_d;
      done_q  <= done_d;
      fault_q <= fault_d;
      code_q  <= code_d;
      if (take_ld) begin
        seg_q  <= ld_seg;
        rpl_q  <= ld_sel[1:0];
        cpl_q  <= cs_sel[1:0];
        addr_q <= dec_addr;
      end
      if ((st_q == ST_RS_LO) && mem_rsp_valid) lo_q <= mem_rsp_data;
      if ((st_q == ST_RS_HI) && mem_rsp_valid) hi_q <= mem_rsp_data;
    end
  end

  seg_cache #(.NUM_SEGS(NUM_SEGS), .SEG_W(SEG_W)) u_cache (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (commit),
    .wr_idx    (seg_q),
    .wr_entry  (chk_entry),
    .acc_idx   (acc_seg),
    .acc_off   (acc_off),
    .acc_valid (acc_valid),
    .acc_entry (rd_entry),
    .acc_fault (acc_fault)
  );

  assign acc_base   = rd_entry.base;
  assign acc_limit  = rd_entry.limit;
  assign acc_attr   = rd_entry.attr;
  assign done       = done_q;
  assign fault      = fault_q;
  assign fault_code = code_q;

  logic unused_cs;
  assign unused_cs = ^{cs_sel[15:2], rd_entry.expand_down};

endmodule

// File: rtl/seg_load_chk.sv
module seg_load_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ld_valid,
  input logic        ld_ready,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic        mem_req_we,
  input logic [31:0] mem_req_addr,
  input logic [31:0] mem_req_wdata,
  input logic        mem_rsp_ready,
  input logic        done,
  input logic        fault,
  input logic [1:0]  fault_code
);
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_we) && $stable(mem_req_wdata));

  p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid && ld_ready |=> !ld_ready || fault);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ld_ready |-> !mem_req_valid && !mem_rsp_ready);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_fault_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !fault);

  p_one_outcome_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault));

  p_fault_coded_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> fault_code != 2'd0);

  p_wb_accessed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_we |-> mem_req_wdata[8] && mem_req_addr[2]);

endmodule

bind seg_load_unit seg_load_chk u_seg_load_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ld_valid      (ld_valid),
  .ld_ready      (ld_ready),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_we    (mem_req_we),
  .mem_req_addr  (mem_req_addr),
  .mem_req_wdata (mem_req_wdata),
  .mem_rsp_ready (mem_rsp_ready),
  .done          (done),
  .fault         (fault),
  .fault_code    (fault_code)
);

// File: tb/tb_seg_load_unit.sv
`timescale 1ns/1ps
module tb_seg_load_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cs_sel = '0;
  logic [31:0] gdt_base = 32'h0, gdt_limit = 32'h3F;
  logic [31:0] ldt_base = 32'h80, ldt_limit = 32'h1F;
  logic        ld_valid = 1'b0, ld_ready;
  logic [1:0]  ld_seg = '0;
  logic [15:0] ld_sel = '0;
  logic        mem_req_valid, mem_req_ready, mem_req_we;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        mem_rsp_valid = 1'b0, mem_rsp_ready;
  logic [31:0] mem_rsp_data = '0;
  logic        done, fault;
  logic [1:0]  fault_code;
  logic [1:0]  acc_seg = '0;
  logic [31:0] acc_off = '0;
  logic        acc_valid, acc_fault;
  logic [31:0] acc_base, acc_limit;
  logic [11:0] acc_attr;

  always #2.5 clk = ~clk;

  seg_load_unit dut (.*);

  // memory model: 64 words, ready low one cycle in three
  logic [31:0] mem [0:63];
  int          cyc = 0;
  int          nreq = 0;
  logic [31:0] last_rd = '0, prev_rd = '0;
  assign mem_req_ready = (cyc % 3) != 2;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_rsp_valid && mem_rsp_ready) mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      nreq <= nreq + 1;
      if (mem_req_we) mem[mem_req_addr[7:2]] <= mem_req_wdata;
      else begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mem[mem_req_addr[7:2]];
        prev_rd <= last_rd;
        last_rd <= mem_req_addr;
      end
    end
  end

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic put_desc(input int w, input logic [31:0] b, input logic [19:0] lim,
                          input bit g, input bit p, input logic [1:0] dpl, input logic [3:0] typ);
    mem[w]   = {b[15:0], lim[15:0]};
    mem[w+1] = {b[31:24], g, 1'b1, 2'b00, lim[19:16], p, dpl, 1'b1, typ, b[23:16]};
  endtask

  typedef struct packed {
    logic [1:0]  seg;
    logic [15:0] sel;
    logic [1:0]  cpl;
    logic [1:0]  code;
    logic [31:0] base;
    logic [31:0] lim;
  } vec_t;

  localparam vec_t VECS [0:13] = '{
    '{2'd1, 16'h0008, 2'd0, 2'd0, 32'h12345678, 32'h00000ABC},
    '{2'd2, 16'h0013, 2'd3, 2'd0, 32'h00400000, 32'h00010FFF},
    '{2'd0, 16'h001B, 2'd3, 2'd2, 32'h0, 32'h0},
    '{2'd1, 16'h0008, 2'd3, 2'd3, 32'h0, 32'h0},
    '{2'd3, 16'h0030, 2'd0, 2'd0, 32'h00001000, 32'h00000200},
    '{2'd1, 16'h002A, 2'd2, 2'd0, 32'h00020000, 32'h0000FFFF},
    '{2'd3, 16'h0033, 2'd0, 2'd3, 32'h0, 32'h0},
    '{2'd0, 16'h0032, 2'd1, 2'd3, 32'h0, 32'h0},
    '{2'd0, 16'h0031, 2'd1, 2'd0, 32'h00001000, 32'h00000200},
    '{2'd2, 16'h003B, 2'd3, 2'd0, 32'h000A0000, 32'h000003FF},
    '{2'd2, 16'h0043, 2'd3, 2'd1, 32'h0, 32'h0},
    '{2'd1, 16'h0007, 2'd3, 2'd0, 32'h55550000, 32'h0FFFFFFF},
    '{2'd1, 16'h0024, 2'd0, 2'd1, 32'h0, 32'h0},
    '{2'd0, 16'h0023, 2'd3, 2'd0, 32'h00008000, 32'h00000FFF}
  };

  logic        m_vld  [4];
  logic [31:0] m_base [4];
  logic [31:0] m_lim  [4];

  task automatic probe(input logic [1:0] s, input logic [31:0] off);
    @(negedge clk);
    acc_seg = s;
    acc_off = off;
    #1;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    put_desc(2,  32'h12345678, 20'h00ABC, 0, 1, 2'd0, 4'h2);
    put_desc(4,  32'h00400000, 20'h00010, 1, 1, 2'd3, 4'h2);
    put_desc(6,  32'h00000000, 20'h0FFFF, 0, 0, 2'd3, 4'h2);
    put_desc(8,  32'h00008000, 20'h00FFF, 0, 1, 2'd3, 4'h6);
    put_desc(10, 32'h00020000, 20'h0FFFF, 0, 1, 2'd2, 4'hA);
    put_desc(12, 32'h00001000, 20'h00200, 0, 1, 2'd1, 4'h2);
    put_desc(14, 32'h000A0000, 20'h003FF, 0, 1, 2'd3, 4'h2);
    put_desc(32, 32'h55550000, 20'h0FFFF, 1, 1, 2'd3, 4'h2);
    put_desc(34, 32'h00000077, 20'h00001, 0, 1, 2'd0, 4'h2);
    for (int i = 0; i < 4; i++) begin m_vld[i] = 0; m_base[i] = 0; m_lim[i] = 0; end

    repeat (3) @(negedge clk);
    // reset state
    check(ld_ready === 1'b1, "R11 ld_ready in reset", {31'b0, ld_ready}, 32'd1);
    check(!done && !fault && !mem_req_valid, "R11 quiet in reset", {29'b0, done, fault, mem_req_valid}, 32'd0);
    rst_n = 1'b1;
    probe(2'd0, 32'h0);
    check(acc_valid === 1'b0, "R11 segment invalid after reset", {31'b0, acc_valid}, 32'd0);
    check(acc_fault === 1'b1, "R8 unloaded register faults", {31'b0, acc_fault}, 32'd1);

    for (int v = 0; v < 14; v++) begin
      vec_t   t;
      int     w;
      logic [31:0] hi_before, tbase;
      int     waitc;
      bit     got_done, got_fault;
      logic [1:0] got_code;
      t = VECS[v];
      tbase = t.sel[2] ? ldt_base : gdt_base;
      w = int'((tbase + {16'b0, t.sel[15:3], 3'b000}) >> 2) + 1;
      hi_before = (w < 64) ? mem[w] : 32'h0;
      @(negedge clk);
      ld_valid = 1'b1; ld_sel = t.sel; ld_seg = t.seg; cs_sel = {14'h0, t.cpl};
      @(negedge clk);
      ld_valid = 1'b0;
      if (t.code != 2'd1)
        check(ld_ready === 1'b0, "R10 busy after accept", {31'b0, ld_ready}, 32'd0);
      waitc = 0;
      while (!done && !fault && waitc < 100) begin @(negedge clk); waitc++; end
      got_done = done; got_fault = fault; got_code = fault_code;
      if (t.code == 2'd0) begin
        check(got_done && !got_fault, "R7 done on success", {30'b0, got_done, got_fault}, 32'd2);
        m_vld[t.seg] = 1; m_base[t.seg] = t.base; m_lim[t.seg] = t.lim;
        check(prev_rd == tbase + {16'b0, t.sel[15:3], 3'b000}, "R1 low word address", prev_rd,
              tbase + {16'b0, t.sel[15:3], 3'b000});
        check(last_rd == prev_rd + 4, "R1 high word address", last_rd, prev_rd + 4);
        check(mem[w] == (hi_before | 32'h100), "R6 accessed bit written back", mem[w], hi_before | 32'h100);
      end else begin
        check(got_fault && !got_done && got_code == t.code,
              (t.code == 2'd1) ? "R2 table bound fault" : (t.code == 2'd2) ? "R3 absent fault" : "R4 privilege fault",
              {29'b0, got_fault, got_code}, {29'b0, 1'b1, t.code});
        if (t.code != 2'd1)
          check(mem[w] == hi_before, "R3 R4 no write-back on fault", mem[w], hi_before);
      end
      @(negedge clk);
      check(!done && !fault && ld_ready, "R7 single-cycle outcome pulse", {29'b0, done, fault, ld_ready}, 32'd1);
      acc_seg = t.seg; #1;
      check(acc_valid == m_vld[t.seg] && acc_base == m_base[t.seg], "R5 cached base", acc_base, m_base[t.seg]);
      check(acc_limit == m_lim[t.seg], "R5 cached scaled limit", acc_limit, m_lim[t.seg]);
    end

    // table bound fault must not touch memory
    begin
      int n0;
      n0 = nreq;
      @(negedge clk);
      ld_valid = 1'b1; ld_sel = 16'h0048; ld_seg = 2'd3; cs_sel = '0;
      @(negedge clk);
      ld_valid = 1'b0;
      check(fault && fault_code == 2'd1, "R2 bound fault code", {30'b0, fault_code}, 32'd1);
      @(negedge clk);
      check(nreq == n0, "R2 no memory request", nreq, n0);
    end

    // offset checks
    probe(2'd0, 32'h00000FFF); check(acc_fault === 1'b1, "R9 expand-down at limit faults", {31'b0, acc_fault}, 1);
    probe(2'd0, 32'h00001000); check(acc_fault === 1'b0, "R9 expand-down above limit passes", {31'b0, acc_fault}, 0);
    probe(2'd0, 32'h00000000); check(acc_fault === 1'b1, "R9 expand-down zero faults", {31'b0, acc_fault}, 1);
    probe(2'd0, 32'hFFFFFFFF); check(acc_fault === 1'b0, "R9 expand-down top passes", {31'b0, acc_fault}, 0);
    probe(2'd2, 32'h000003FF); check(acc_fault === 1'b0, "R8 at limit passes", {31'b0, acc_fault}, 0);
    probe(2'd2, 32'h00000400); check(acc_fault === 1'b1, "R8 past limit faults", {31'b0, acc_fault}, 1);
    probe(2'd1, 32'h0FFFFFFF); check(acc_fault === 1'b0, "R8 scaled limit passes", {31'b0, acc_fault}, 0);
    probe(2'd1, 32'h10000000); check(acc_fault === 1'b1, "R8 scaled limit exceeded", {31'b0, acc_fault}, 1);
    probe(2'd3, 32'h0);
    check(acc_attr[6:5] == 2'd1, "R5 cached DPL", {30'b0, acc_attr[6:5]}, 32'd1);

    // reset again clears the cache
    @(negedge clk); rst_n = 1'b0;
    probe(2'd2, 32'h0);
    check(acc_valid === 1'b0 && acc_fault === 1'b1, "R11 reset clears registers", {30'b0, acc_valid, acc_fault}, 32'd1);
    rst_n = 1'b1;

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%08h expected=%08h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule